// File: doc/BRIEF.md
# MIDI Channel Message Parser

This block sits behind a MIDI UART receiver. It takes one byte at a time from the receiver and builds complete channel voice messages that carry two data bytes. Each complete message is presented as a single output beat. The beat holds the message kind, the channel, the first data byte and the second data byte.

The parser only accepts status bytes that open a two-data-byte message. These are note off, note on, polyphonic pressure, control change and pitch bend. Once such a status byte has been latched, any following pairs of data bytes reuse it, so running status is supported. A fresh recognised status byte always restarts collection of the data bytes. A note on whose velocity is zero is reported as a note off.

Top module: `midi_msg_parser`

## Requirements
- R1: After reset, `msg_valid` is low. No message is emitted until a recognised status byte has been received.
- R2: A status byte is a byte with bit 7 set, and its kind is taken from bits 7:4. A status byte is recognised when bits 7:4 are 8, 9, A, B or E. When a recognised status byte is followed by two data bytes, the parser emits one message. `msg_valid` is high during the clock cycle after the edge that accepted the second data byte. In that cycle `msg_kind` equals bits 7:4 of the status byte, `msg_chan` equals its bits 3:0, and `msg_d1` and `msg_d2` equal bits 6:0 of the two data bytes.
- R3: Data bytes are bytes with bit 7 clear. Data bytes received before any recognised status byte produce no output.
- R4: A status byte whose bits 7:4 are C, D or F is ignored. Collection continues as if that byte had not arrived, and any first data byte already collected is kept.
- R5: A recognised status byte that arrives while data bytes are being collected replaces the latched status. Any first data byte already collected is discarded, and collection waits again for a first data byte.
- R6: After a message has been emitted, every further pair of data bytes emits another message with the same latched status.
- R7: `msg_valid` is high for exactly one clock per completed message.
- R8: When the kind is note on (9) and the second data byte is 0, the message is emitted with `msg_kind` 8. A note on with a nonzero second data byte keeps kind 9.
- R9: A byte accepted in the same cycle as `msg_valid` is processed normally. The message shown in that cycle is not altered by it.
- R10: While `byte_valid` is low, the value on `byte_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Received byte from the UART |
| byte_valid | input | 1 | `byte_in` holds a new byte this cycle |
| msg_kind | output | 4 | Message kind (status bits 7:4, after the note-on rewrite) |
| msg_chan | output | 4 | Channel (status bits 3:0) |
| msg_d1 | output | 7 | First data byte |
| msg_d2 | output | 7 | Second data byte |
| msg_valid | output | 1 | One-cycle strobe marking a completed message |

## Verification
The emit cycle can coincide with the acceptance of the next input byte. That byte may be a first data byte under running status, or a new recognised status byte. The bench provokes both cases by streaming bytes with `byte_valid` held high back to back, so that a byte lands exactly on the cycle where `msg_valid` is high. The scoreboard then requires two things. The pulse must carry the old message unchanged, and the following message must be assembled from the byte that arrived during the emit cycle.

// File: rtl/midi_parser_pkg.sv
package midi_parser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA1 = 2'd1,
    ST_DATA2 = 2'd2,
    ST_EMIT  = 2'd3
  } parse_state_t;

  // Upper-nibble codes of status bytes that open a two-data-byte message
  function automatic logic kind_takes_two(input logic [3:0] hi);
    case (hi)
      4'h8, 4'h9, 4'hA, 4'hB, 4'hE: kind_takes_two = 1'b1;
      default:                      kind_takes_two = 1'b0;
    endcase
  endfunction

  // A note on whose velocity is zero is reported as a note off
  function automatic logic [3:0] reported_kind(input logic [3:0] hi, input logic [6:0] vel);
    if (hi == 4'h9 && vel == 7'd0) reported_kind = 4'h8;
    else                           reported_kind = hi;
  endfunction

endpackage

// File: rtl/midi_byte_class.sv
module midi_byte_class #(
  parameter int DATA_W = 7,
  localparam int BYTE_W = DATA_W + 1
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_valid,
  output logic              ev_status_ok,
  output logic              ev_status_bad,
  output logic              ev_data
);
  import midi_parser_pkg::*;

  logic flag_msb;
  assign flag_msb = byte_in[BYTE_W-1];

  always_comb begin
    ev_data       = byte_valid && !flag_msb;
    ev_status_ok  = byte_valid && flag_msb &&  kind_takes_two(byte_in[BYTE_W-1 -: 4]);
    ev_status_bad = byte_valid && flag_msb && !kind_takes_two(byte_in[BYTE_W-1 -: 4]);
  end
endmodule

// File: rtl/midi_parse_fsm.sv
module midi_parse_fsm #(
  parameter int DATA_W = 7,
  localparam int BYTE_W = DATA_W + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [BYTE_W-1:0]             byte_in,
  input  logic                          ev_status_ok,
  input  logic                          ev_data,
  output midi_parser_pkg::parse_state_t state,
  output logic [BYTE_W-1:0]             status_q,
  output logic [DATA_W-1:0]             d1_q,
  output logic [DATA_W-1:0]             d2_q
);
  import midi_parser_pkg::*;

  parse_state_t nxt;

  always_comb begin
    nxt = state;
    if (ev_status_ok) begin
      nxt = ST_DATA1;
    end else if (ev_data) begin
      case (state)
        ST_DATA1, ST_EMIT: nxt = ST_DATA2;
        ST_DATA2:          nxt = ST_EMIT;
        default:           nxt = ST_IDLE;
      endcase
    end else if (state == ST_EMIT) begin
      nxt = ST_DATA1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      status_q <= '0;
      d1_q     <= '0;
      d2_q     <= '0;
    end else begin
      state <= nxt;
      if (ev_status_ok) status_q <= byte_in;
      if (ev_data && (state == ST_DATA1 || state == ST_EMIT)) d1_q <= byte_in[DATA_W-1:0];
      if (ev_data && state == ST_DATA2) d2_q <= byte_in[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/midi_msg_fmt.sv
module midi_msg_fmt #(
  parameter int DATA_W = 7,
  localparam int BYTE_W = DATA_W + 1
) (
  input  midi_parser_pkg::parse_state_t state,
  input  logic [BYTE_W-1:0]             status_q,
  input  logic [DATA_W-1:0]             d1_q,
  input  logic [DATA_W-1:0]             d2_q,
  output logic [3:0]                    msg_kind,
  output logic [3:0]                    msg_chan,
  output logic [DATA_W-1:0]             msg_d1,
  output logic [DATA_W-1:0]             msg_d2,
  output logic                          msg_valid
);
  import midi_parser_pkg::*;

  always_comb begin
    msg_valid = (state == ST_EMIT);
    msg_kind  = reported_kind(status_q[BYTE_W-1 -: 4], d2_q);
    msg_chan  = status_q[3:0];
    msg_d1    = d1_q;
    msg_d2    = d2_q;
  end
endmodule

// File: rtl/midi_msg_parser.sv
module midi_msg_parser #(
  parameter int DATA_W = 7,
  localparam int BYTE_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_valid,
  output logic [3:0]        msg_kind,
  output logic [3:0]        msg_chan,
  output logic [DATA_W-1:0] msg_d1,
  output logic [DATA_W-1:0] msg_d2,
  output logic              msg_valid
);
  import midi_parser_pkg::*;

  logic              ev_status_ok;
  logic              ev_status_bad;
  logic              ev_data;
  parse_state_t      state;
  logic [BYTE_W-1:0] status_q;
  logic [DATA_W-1:0] d1_q;
  logic [DATA_W-1:0] d2_q;

  midi_byte_class #(.DATA_W(DATA_W)) u_class (
    .byte_in      (byte_in),
    .byte_valid   (byte_valid),
    .ev_status_ok (ev_status_ok),
    .ev_status_bad(ev_status_bad),
    .ev_data      (ev_data)
  );

  midi_parse_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .byte_in     (byte_in),
    .ev_status_ok(ev_status_ok),
    .ev_data     (ev_data),
    .state       (state),
    .status_q    (status_q),
    .d1_q        (d1_q),
    .d2_q        (d2_q)
  );

  midi_msg_fmt #(.DATA_W(DATA_W)) u_fmt (
    .state    (state),
    .status_q (status_q),
    .d1_q     (d1_q),
    .d2_q     (d2_q),
    .msg_kind (msg_kind),
    .msg_chan (msg_chan),
    .msg_d1   (msg_d1),
    .msg_d2   (msg_d2),
    .msg_valid(msg_valid)
  );
endmodule

// File: rtl/midi_msg_parser_chk.sv
module midi_msg_parser_chk #(
  parameter int DATA_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_valid,
  input logic              ev_status_ok,
  input logic              ev_status_bad,
  input logic              ev_data,
  input logic [1:0]        state,
  input logic [3:0]        msg_kind,
  input logic [DATA_W-1:0] msg_d2,
  input logic              msg_valid
);
  import midi_parser_pkg::*;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    msg_valid |=> !msg_valid);

  a_r2_pulse_follows_data: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> $past(byte_valid && ev_data));

  a_r8_no_silent_note_on: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !(msg_kind == 4'h9 && msg_d2 == '0));

  a_r4_bad_status_holds: assert property (@(posedge clk) disable iff (rst)
    (ev_status_bad && state != ST_EMIT) |=> $stable(state));

  a_r3_idle_ignores_data: assert property (@(posedge clk) disable iff (rst)
    (ev_data && state == ST_IDLE) |=> (state == ST_IDLE));

  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    ev_status_ok |=> (state == ST_DATA1));

  a_r10_idle_input: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |-> !(ev_data || ev_status_ok || ev_status_bad));

  a_r2_kind_legal: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> kind_takes_two(msg_kind));
endmodule

bind midi_msg_parser midi_msg_parser_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .byte_valid   (byte_valid),
  .ev_status_ok (ev_status_ok),
  .ev_status_bad(ev_status_bad),
  .ev_data      (ev_data),
  .state        (state),
  .msg_kind     (msg_kind),
  .msg_d2       (msg_d2),
  .msg_valid    (msg_valid)
);

// File: tb/midi_msg_parser_tb.sv
module midi_msg_parser_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic       byte_valid = 1'b0;
  logic [3:0] msg_kind, msg_chan;
  logic [6:0] msg_d1, msg_d2;
  logic       msg_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed {
    logic [3:0] kind;
    logic [3:0] chan;
    logic [6:0] d1;
    logic [6:0] d2;
  } exp_t;

  exp_t sb[$];
  string tag_q[$];

  always #2 clk = ~clk;

  midi_msg_parser u_dut (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_valid(byte_valid),
    .msg_kind(msg_kind), .msg_chan(msg_chan), .msg_d1(msg_d1),
    .msg_d2(msg_d2), .msg_valid(msg_valid)
  );

  // Bench model of the reported kind
  function automatic logic [3:0] model_kind(input logic [7:0] st, input logic [6:0] v);
    logic [3:0] k;
    k = st >> 4;
    return (v != 0) ? k : ((k == 4'd9) ? 4'd8 : k);
  endfunction

  task automatic expect_msg(input logic [7:0] st, input logic [6:0] a, input logic [6:0] b,
                            input string tag);
    exp_t e;
    e.kind = model_kind(st, b);
    e.chan = st[3:0];
    e.d1 = a;
    e.d2 = b;
    sb.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic put(input logic [7:0] b);
    byte_in = b;
    byte_valid = 1'b1;
    @(posedge clk); #1;
    byte_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      byte_in = 8'hFF ^ 8'(i * 37);
      @(posedge clk); #1;
    end
  endtask

  // Monitor: pops the scoreboard on each pulse
  always @(negedge clk) begin
    if (!rst && msg_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R7/R3/R4: unexpected message kind=%h chan=%h d1=%h d2=%h, expected none",
                 msg_kind, msg_chan, msg_d1, msg_d2);
      end else begin
        exp_t e;
        string t;
        e = sb.pop_front();
        t = tag_q.pop_front();
        if ({msg_kind, msg_chan, msg_d1, msg_d2} !== e) begin
          fails++;
          $display("FAIL %s: got kind=%h chan=%h d1=%h d2=%h, expected kind=%h chan=%h d1=%h d2=%h",
                   t, msg_kind, msg_chan, msg_d1, msg_d2, e.kind, e.chan, e.d1, e.d2);
        end
      end
    end
  end

  initial begin
    int wd;
    for (wd = 0; wd < 20000 && !done; wd++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (msg_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: msg_valid after reset = %b, expected 0", msg_valid);
    end
    rst = 1'b0;
    gap(2);

    // R1, R3: data bytes before any status produce nothing
    put(8'h12); put(8'h34); put(8'h56); gap(3);

    // R2: each recognised kind, with gaps between bytes
    expect_msg(8'h83, 7'h3C, 7'h40, "R2 note off");
    put(8'h83); gap(1); put(8'h3C); gap(2); put(8'h40); gap(3);
    expect_msg(8'hA5, 7'h11, 7'h22, "R2 poly pressure");
    put(8'hA5); put(8'h11); put(8'h22); gap(2);
    expect_msg(8'hBF, 7'h07, 7'h7F, "R2 control change");
    put(8'hBF); put(8'h07); put(8'h7F); gap(2);
    expect_msg(8'hE0, 7'h00, 7'h40, "R2 pitch bend");
    put(8'hE0); put(8'h00); put(8'h40); gap(2);

    // R8: note on, nonzero and zero velocity
    expect_msg(8'h92, 7'h45, 7'h64, "R8 note on kept");
    put(8'h92); put(8'h45); put(8'h64); gap(2);
    expect_msg(8'h92, 7'h45, 7'h00, "R8 zero velocity as note off");
    put(8'h45); put(8'h00); gap(2);

    // R6: running status, several pairs
    expect_msg(8'h92, 7'h30, 7'h31, "R6 running 1");
    expect_msg(8'h92, 7'h32, 7'h33, "R6 running 2");
    put(8'h30); gap(1); put(8'h31); gap(2); put(8'h32); put(8'h33); gap(2);

    // R4: unrecognised status between data bytes keeps the first one
    expect_msg(8'hB4, 7'h01, 7'h02, "R4 ignored C/D/F status");
    put(8'hB4); put(8'h01); put(8'hC7); put(8'hD1); put(8'hF8); put(8'h02); gap(2);
    put(8'hFE); put(8'hC0); gap(2);

    // R5: new recognised status mid-message discards collected data
    expect_msg(8'h96, 7'h50, 7'h51, "R5 restart");
    put(8'h81); put(8'h20); put(8'h96); put(8'h50); put(8'h51); gap(2);
    expect_msg(8'hE9, 7'h0A, 7'h0B, "R5 restart after first byte");
    put(8'hB3); put(8'h66); put(8'hE9); put(8'h0A); put(8'h0B); gap(2);

    // R9: byte in the emit cycle, running status and new status
    expect_msg(8'h97, 7'h3C, 7'h40, "R9 emit cycle old message");
    expect_msg(8'h97, 7'h3E, 7'h41, "R9 running data in emit cycle");
    put(8'h97); put(8'h3C); put(8'h40); put(8'h3E); put(8'h41); gap(2);
    expect_msg(8'h91, 7'h10, 7'h20, "R9 old message with status in emit cycle");
    expect_msg(8'hB2, 7'h07, 7'h40, "R9 status in emit cycle");
    put(8'h91); put(8'h10); put(8'h20); put(8'hB2); put(8'h07); put(8'h40); gap(2);

    // R10: byte_in changes without byte_valid
    expect_msg(8'hA8, 7'h12, 7'h13, "R10 invalid bytes ignored");
    put(8'hA8); gap(1);
    byte_in = 8'h90; @(posedge clk); #1;
    byte_in = 8'h55; @(posedge clk); #1;
    put(8'h12);
    byte_in = 8'h77; @(posedge clk); #1;
    put(8'h13); gap(3);

    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2/R7: %0d expected messages never seen, expected 0", sb.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule